// File: doc/BRIEF.md
# Decimal-Capable 8-bit Arithmetic and Logic Unit

This block is the data-path ALU for an 8-bit processor core. Each request carries an operation code, the accumulator or index register value, an operand byte, and the current carry, overflow and decimal flags. The block returns the 8-bit result together with new N, V, Z and C flags. It covers addition with carry and subtraction with borrow in both plain binary and packed BCD, unsigned compare, the bitwise AND, OR and XOR, and single-bit shifts and rotates in both directions.

Decimal flag behaviour matches the older NMOS-style cores. In decimal addition, Z follows the binary sum. N and V follow the partially corrected value, taken before the upper digit is adjusted. In decimal subtraction, only the result byte is corrected, and every flag follows the binary difference.

Requests enter through a valid/ready port and results leave through a second valid/ready port, with one register stage in between. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high when the output register is empty, or when it is being drained in that same cycle. While the consumer holds `out_ready` low, the output register and all result pins keep their values. Results leave in the order the requests were accepted, one per cycle at full rate.

Top module: `alu_bcd8`

## Requirements
- R1: Code 0 with decimal clear computes A+M+C. The result is the low byte. C is set when the sum exceeds 0xFF. V is set when A and M share bit 7 and the result's bit 7 differs from it. N is result bit 7, and Z is set for a zero result.
- R2: Code 0 with decimal set forms a low digit sum A[3:0]+M[3:0]+C. When that sum exceeds 9, 6 is added to it and 1 is carried into the upper digit sum A[7:4]+M[7:4]. When the upper digit sum exceeds 9, 6 is added to it. The result is the two corrected digits. C is set when the corrected value (upper sum × 16 + low digit) exceeds 0xF0.
- R3: In decimal addition, Z is set when the low byte of the binary sum A+M+C is zero. N and V are taken from the value before the upper digit correction: N is its bit 7, and V is set when A and M share bit 7 and that value's bit 7 differs from A's.
- R4: Code 1 with decimal clear computes A−M−(1−C). C is set when no borrow occurs. V is set when A and M differ in bit 7 and the result's bit 7 differs from A's. N and Z follow the result.
- R5: Code 1 with decimal set subtracts digit-wise with borrow. A borrow out of the low digit takes 6 from that digit. A borrow out of the upper digit takes 6 from that digit. N, V, Z and C are those of the binary difference in R4.
- R6: Code 2 (compare) returns A unchanged as the result. It sets C when A ≥ M unsigned, sets Z when A equals M, and sets N to bit 7 of A−M. V passes through, and the decimal flag has no effect.
- R7: Codes 3, 4 and 5 return A AND M, A OR M and A XOR M. N and Z follow the result, and C and V pass through unchanged.
- R8: Code 6 shifts left, filling with 0. Code 7 shifts right, filling with 0. The bit shifted out (bit 7 for left, bit 0 for right) becomes C.
- R9: Code 8 rotates left and code 9 rotates right. The incoming carry fills the vacated end (bit 0 for left, bit 7 for right), and the bit shifted out becomes C.
- R10: For all shift and rotate codes, V passes through and N and Z follow the result.
- R11: Codes 10 to 15 return A unchanged, with C and V passed through and N and Z taken from A.
- R12: A request is accepted on an edge where `in_valid` and `in_ready` are both high, and `in_ready` is high exactly when the output register is empty or is being read in that cycle. While `out_valid` is high and `out_ready` is low, all result pins hold their values. Results appear one cycle after acceptance, in acceptance order.
- R13: While reset is asserted and on the first cycle after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_a | input | 8 | Accumulator or register value |
| in_m | input | 8 | Operand byte |
| in_carry | input | 1 | Incoming carry flag |
| in_ovf | input | 1 | Incoming overflow flag |
| in_dec | input | 1 | Decimal mode flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 8 | Result byte |
| out_n | output | 1 | Negative flag |
| out_v | output | 1 | Overflow flag |
| out_z | output | 1 | Zero flag |
| out_c | output | 1 | Carry flag |

## Verification
The output register can be drained and reloaded in the same cycle: the previous result leaves while a new request is accepted. A stretch of the bench keeps `in_valid` high while `out_ready` follows a pseudo-random pattern, so that drain-and-load cycles are mixed with stall cycles. Every result is compared in order against a queue of values the bench computed from the requests it had accepted, which exposes a lost, duplicated or overwritten result. On each stall cycle, the bench also checks that the result pins have not moved.

// File: rtl/alu_bcd8_pkg.sv
package alu_bcd8_pkg;

  localparam int DW      = 8;
  localparam int DIG_W   = DW / 2;
  localparam int OP_W    = 4;
  localparam int DIG_MAX = 9;
  localparam int DIG_ADJ = 6;
  localparam int CARRY_LIMIT = 16'h00F0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7,
    OP_ROL = 4'd8,
    OP_ROR = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/alu_bcd8_arith.sv
module alu_bcd8_arith
  import alu_bcd8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          cin,
  input  logic          dec,
  input  logic          sub,
  output logic [DW-1:0] res,
  output alu_flags_t    flags
);

  // plain binary sum and difference
  logic [DW:0] bin_sum;
  logic [DW:0] bin_dif;
  assign bin_sum = {1'b0, a} + {1'b0, m} + {{DW{1'b0}}, cin};
  assign bin_dif = {1'b0, a} + {1'b0, ~m} + {{DW{1'b0}}, cin};

  // decimal add: low digit, partial value, upper correction
  logic [DIG_W+1:0] lo_raw;
  logic             lo_cy;
  logic [DIG_W-1:0] lo_dig;
  logic [DW:0]      mid;
  logic [DW+1:0]    fixed;
  logic             hi_over;

  always_comb begin
    lo_raw = {2'b00, a[DIG_W-1:0]} + {2'b00, m[DIG_W-1:0]} + {{(DIG_W+1){1'b0}}, cin};
    lo_cy  = (lo_raw > (DIG_W+2)'(DIG_MAX));
    lo_dig = lo_cy ? (lo_raw[DIG_W-1:0] + DIG_W'(DIG_ADJ)) : lo_raw[DIG_W-1:0];
    mid    = {1'b0, a[DW-1:DIG_W], {DIG_W{1'b0}}}
           + {1'b0, m[DW-1:DIG_W], {DIG_W{1'b0}}}
           + {{DIG_W{1'b0}}, lo_cy, {DIG_W{1'b0}}}
           + {{(DIG_W+1){1'b0}}, lo_dig};
    hi_over = (mid[DW:DIG_W] > (DIG_W+1)'(DIG_MAX));
    fixed   = hi_over ? ({1'b0, mid} + (DW+2)'(DIG_ADJ << DIG_W)) : {1'b0, mid};
  end

  // decimal subtract: digit-wise borrow with 6 taken from a borrowing digit
  logic [DIG_W:0]   lo_d;
  logic [DIG_W-1:0] lo_fix;
  logic [DIG_W:0]   hi_d;
  logic [DIG_W-1:0] hi_fix;

  always_comb begin
    lo_d   = {1'b0, a[DIG_W-1:0]} - {1'b0, m[DIG_W-1:0]} - {{DIG_W{1'b0}}, ~cin};
    lo_fix = lo_d[DIG_W] ? (lo_d[DIG_W-1:0] - DIG_W'(DIG_ADJ)) : lo_d[DIG_W-1:0];
    hi_d   = {1'b0, a[DW-1:DIG_W]} - {1'b0, m[DW-1:DIG_W]} - {{DIG_W{1'b0}}, lo_d[DIG_W]};
    hi_fix = hi_d[DIG_W] ? (hi_d[DIG_W-1:0] - DIG_W'(DIG_ADJ)) : hi_d[DIG_W-1:0];
  end

  always_comb begin
    if (sub) begin
      res     = dec ? {hi_fix, lo_fix} : bin_dif[DW-1:0];
      flags.c = bin_dif[DW];
      flags.v = (a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ bin_dif[DW-1]);
      flags.n = bin_dif[DW-1];
      flags.z = (bin_dif[DW-1:0] == '0);
    end else if (dec) begin
      res     = fixed[DW-1:0];
      flags.c = (fixed > (DW+2)'(CARRY_LIMIT));
      flags.v = ~(a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ mid[DW-1]);
      flags.n = mid[DW-1];
      flags.z = (bin_sum[DW-1:0] == '0);
    end else begin
      res     = bin_sum[DW-1:0];
      flags.c = bin_sum[DW];
      flags.v = ~(a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ bin_sum[DW-1]);
      flags.n = bin_sum[DW-1];
      flags.z = (bin_sum[DW-1:0] == '0);
    end
  end

endmodule

// File: rtl/alu_bcd8_bitops.sv
module alu_bcd8_bitops
  import alu_bcd8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);

  always_comb begin
    res  = a;
    cout = cin;
    case (op)
      OP_AND: res = a & m;
      OP_OR:  res = a | m;
      OP_XOR: res = a ^ m;
      OP_SHL: begin res = {a[DW-2:0], 1'b0}; cout = a[DW-1]; end
      OP_SHR: begin res = {1'b0, a[DW-1:1]}; cout = a[0];    end
      OP_ROL: begin res = {a[DW-2:0], cin};  cout = a[DW-1]; end
      OP_ROR: begin res = {cin, a[DW-1:1]};  cout = a[0];    end
      default: begin res = a; cout = cin; end
    endcase
  end

endmodule

// File: rtl/alu_bcd8.sv
module alu_bcd8
  import alu_bcd8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_m,
  input  logic            in_carry,
  input  logic            in_ovf,
  input  logic            in_dec,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_res,
  output logic            out_n,
  output logic            out_v,
  output logic            out_z,
  output logic            out_c
);

  alu_op_e op;
  assign op = alu_op_e'(in_op);

  // compare reuses the subtractor with carry forced and decimal ignored
  logic is_cmp;
  logic ar_sub;
  logic ar_dec;
  logic ar_cin;
  assign is_cmp = (op == OP_CMP);
  assign ar_sub = (op == OP_SUB) | is_cmp;
  assign ar_dec = in_dec & ~is_cmp;
  assign ar_cin = in_carry | is_cmp;

  logic [DW-1:0] ar_res;
  alu_flags_t    ar_flags;

  alu_bcd8_arith u_arith (
    .a     (in_a),
    .m     (in_m),
    .cin   (ar_cin),
    .dec   (ar_dec),
    .sub   (ar_sub),
    .res   (ar_res),
    .flags (ar_flags)
  );

  logic [DW-1:0] bo_res;
  logic          bo_cout;

  alu_bcd8_bitops u_bitops (
    .op   (op),
    .a    (in_a),
    .m    (in_m),
    .cin  (in_carry),
    .res  (bo_res),
    .cout (bo_cout)
  );

  logic [DW-1:0] nxt_res;
  alu_flags_t    nxt_flags;

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: begin
        nxt_res   = ar_res;
        nxt_flags = ar_flags;
      end
      OP_CMP: begin
        nxt_res   = in_a;
        nxt_flags = '{n: ar_flags.n, v: in_ovf, z: ar_flags.z, c: ar_flags.c};
      end
      default: begin
        nxt_res   = bo_res;
        nxt_flags = '{n: bo_res[DW-1], v: in_ovf, z: (bo_res == '0), c: bo_cout};
      end
    endcase
  end

  // single output register stage with pass-through ready
  logic          vld_q;
  logic [DW-1:0] res_q;
  alu_flags_t    flg_q;
  logic          take;

  assign in_ready = ~vld_q | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      if (take) begin
        vld_q <= 1'b1;
        res_q <= nxt_res;
        flg_q <= nxt_flags;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_res   = res_q;
  assign out_n     = flg_q.n;
  assign out_v     = flg_q.v;
  assign out_z     = flg_q.z;
  assign out_c     = flg_q.c;

endmodule

// File: rtl/alu_bcd8_chk.sv
module alu_bcd8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [3:0] in_op,
  input logic [7:0] in_a,
  input logic [7:0] in_m,
  input logic       in_carry,
  input logic       in_ovf,
  input logic       in_dec,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_res,
  input logic       out_n,
  input logic       out_v,
  input logic       out_z,
  input logic       out_c
);

  logic acc;
  assign acc = in_valid & in_ready;

  // R12: a stalled result does not move
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res)
      && $stable(out_n) && $stable(out_v) && $stable(out_z) && $stable(out_c));

  // R12: an accepted request shows up next cycle
  p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R13: reset empties the output register
  p_reset_r13: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R1 and R3: Z of an add follows the binary byte sum in both modes
  p_add_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd0 |=> out_z ==
      (8'($past(in_a) + $past(in_m) + {7'd0, $past(in_carry)}) == 8'd0));

  // R6: compare leaves the register value as result and keeps V
  p_cmp_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd2 |=> out_res == $past(in_a) && out_v == $past(in_ovf)
      && out_c == ($past(in_a) >= $past(in_m)));

  // R7: bitwise operations pass C and V
  p_logic_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 4'd3 || in_op == 4'd4 || in_op == 4'd5) |=>
      out_c == $past(in_carry) && out_v == $past(in_ovf));

  // R8: left shift moves bit 7 into carry
  p_shl_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd6 |=> out_c == $past(in_a[7]) && out_res[0] == 1'b0);

  // R9: right rotate puts the old carry in bit 7
  p_ror_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd9 |=> out_res[7] == $past(in_carry) && out_c == $past(in_a[0]));

  // R5: flags of a decimal subtract equal those of the binary difference
  p_dsub_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd1 && in_dec |=> out_c ==
      ({1'b0, $past(in_a)} >= ({1'b0, $past(in_m)} + {8'd0, ~$past(in_carry)})));

endmodule

bind alu_bcd8 alu_bcd8_chk chk_i (.*);

// File: tb/alu_bcd8_tb_top.sv
module alu_bcd8_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_m = '0;
  logic       in_carry = 1'b0;
  logic       in_ovf = 1'b0;
  logic       in_dec = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_res;
  logic       out_n, out_v, out_z, out_c;

  always #5 clk = ~clk;

  alu_bcd8 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_m(in_m), .in_carry(in_carry),
    .in_ovf(in_ovf), .in_dec(in_dec), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_n(out_n),
    .out_v(out_v), .out_z(out_z), .out_c(out_c)
  );

  typedef struct {
    int    r;
    bit    n, v, z, c;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  bit   rand_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic exp_t model(int op, int a, int m, int c, int v, int d);
    exp_t e;
    int s, lo, lc, ld, hi, inter, fin, dif, b;
    e.v = v[0];
    e.c = c[0];
    case (op)
      0: begin
        s = a + m + c;
        if (d == 0) begin
          e.r = s % 256; e.c = (s > 255);
          e.v = (((a ^ m) & 128) == 0) && (((a ^ e.r) & 128) != 0);
          e.n = (e.r >= 128); e.z = (e.r == 0); e.tag = "R1";
        end else begin
          lo = (a % 16) + (m % 16) + c;
          lc = (lo > 9) ? 1 : 0;
          ld = (lc == 1) ? ((lo + 6) % 16) : lo;
          hi = (a / 16) + (m / 16) + lc;
          inter = hi * 16 + ld;
          e.n = ((inter / 128) % 2) == 1;
          e.v = (((a ^ inter) & 128) != 0) && (((a ^ m) & 128) == 0);
          e.z = (s % 256) == 0;
          if (hi > 9) hi = hi + 6;
          fin = hi * 16 + ld;
          e.c = (fin > 240); e.r = fin % 256; e.tag = "R2/R3";
        end
      end
      1: begin
        dif = a - m - (1 - c);
        e.r = (dif + 256) % 256; e.c = (dif >= 0);
        e.v = (((a ^ m) & 128) != 0) && (((a ^ e.r) & 128) != 0);
        e.n = (e.r >= 128); e.z = (e.r == 0); e.tag = "R4";
        if (d != 0) begin
          lo = (a % 16) - (m % 16) - (1 - c);
          b = (lo < 0) ? 1 : 0;
          ld = (b == 1) ? ((lo - 6 + 32) % 16) : lo;
          hi = (a / 16) - (m / 16) - b;
          if (hi < 0) hi = hi - 6;
          e.r = ((hi + 32) % 16) * 16 + ld; e.tag = "R5";
        end
      end
      2: begin
        e.r = a; e.c = (a >= m); e.z = (a == m);
        e.n = (((a - m + 256) % 256) >= 128); e.tag = "R6";
      end
      3, 4, 5: begin
        e.r = (op == 3) ? (a & m) : (op == 4) ? (a | m) : (a ^ m);
        e.n = (e.r >= 128); e.z = (e.r == 0); e.tag = "R7";
      end
      6, 7, 8, 9: begin
        if (op == 6 || op == 8) begin
          e.r = ((a * 2) % 256) + ((op == 8) ? c : 0); e.c = (a >= 128);
        end else begin
          e.r = (a / 2) + ((op == 9) ? c * 128 : 0); e.c = (a % 2) == 1;
        end
        e.n = (e.r >= 128); e.z = (e.r == 0);
        e.tag = (op < 8) ? "R8/R10" : "R9/R10";
      end
      default: begin
        e.r = a; e.n = (a >= 128); e.z = (a == 0); e.tag = "R11";
      end
    endcase
    return e;
  endfunction

  // consumer readiness
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rand_ready ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  // monitor away from the active edge
  bit         stall_prev = 0;
  logic [11:0] snap;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        checks++;
        if (!out_valid || snap != {out_res, out_n, out_v, out_z, out_c}) begin
          errors++;
          $display("FAIL R12 hold: got v=%0b %03h expected v=1 %03h", out_valid,
                   {out_res, out_n, out_v, out_z, out_c}, snap);
        end
      end
      if (in_valid && in_ready)
        q.push_back(model(int'(in_op), int'(in_a), int'(in_m), int'(in_carry),
                          int'(in_ovf), int'(in_dec)));
      if (out_valid && out_ready) begin
        exp_t e;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R12: result %02h with nothing expected", out_res);
        end else begin
          e = q.pop_front();
          if (int'(out_res) != e.r || out_n != e.n || out_v != e.v ||
              out_z != e.z || out_c != e.c) begin
            errors++;
            $display("FAIL %s: res=%02h nvzc=%b%b%b%b expected res=%02h nvzc=%b%b%b%b",
                     e.tag, out_res, out_n, out_v, out_z, out_c,
                     e.r[7:0], e.n, e.v, e.z, e.c);
          end
        end
      end
      stall_prev = out_valid && !out_ready;
      snap = {out_res, out_n, out_v, out_z, out_c};
    end
  end

  task automatic send(int op, int a, int m, int c, int v, int d);
    in_op = op[3:0]; in_a = a[7:0]; in_m = m[7:0];
    in_carry = c[0]; in_ovf = v[0]; in_dec = d[0]; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    // R13: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R13 in reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R13 after reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    @(posedge clk); #1;

    // R1 R2 R3 R4 R5: add and subtract, both modes, every m residue covered
    for (int d = 0; d < 2; d++)
      for (int op = 0; op < 2; op++)
        for (int a = 0; a < 256; a++)
          for (int mb = 0; mb < 256; mb += 4)
            send(op, a, mb | (a % 4), ((a / 2) ^ (mb / 4)) % 2, a % 2, d);

    // R6: compare, decimal flag set to show it is ignored
    for (int a = 0; a < 256; a++)
      for (int mb = 0; mb < 256; mb += 4)
        send(2, a, mb | ((a / 4) % 4), a % 2, (mb / 4) % 2, 1);

    // R7: bitwise operations
    for (int op = 3; op < 6; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 16; k++)
          send(op, a, (k * 37 + a * 3) % 256, k % 2, (k / 2) % 2, 0);

    // R8 R9 R10: shifts and rotates
    for (int op = 6; op < 10; op++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++)
          send(op, a, 255 - a, c, (a / 3) % 2, 0);

    // R11: unused codes
    for (int op = 10; op < 16; op++)
      for (int k = 0; k < 16; k++)
        send(op, k * 17, k, k % 2, (k / 2) % 2, k % 2);

    // R12: back-pressure with drain and load in the same cycle
    rand_ready = 1;
    for (int i = 0; i < 3000; i++)
      send(i % 16, (i * 7) % 256, (i * 13 + 5) % 256, (i / 3) % 2, (i / 5) % 2, (i / 16) % 2);
    in_valid = 1'b0;
    while (q.size() != 0) @(posedge clk);
    rand_ready = 0;
    repeat (4) @(posedge clk);
    summary();
  end

endmodule